// File: doc/BRIEF.md
# Event Buffer Token Manager

This block hands out fixed-size regions of a large external memory to incoming events. Every region is named by a 12-bit token. Free tokens wait in a free list. When the first word of an event arrives, the block takes the token at the head of that list. It builds byte addresses from the token and the word index, and it passes each 33-bit word to a request/acknowledge memory write port. Bit 32 of a word marks the last word of its event.

When an event is complete, its token and its word count go into a readout queue. A downstream reader takes each entry from that queue, copies the region out to the output link, and then hands the token back. The token then joins the tail of the free list. A region holds 32 kB, which is 8192 words. A longer event is cut short at that limit, and the cut is flagged in the last stored word. A status output reports when no token is left, so that the external deadtime logic can hold off new events.

Top module: `event_buf_mgr`

## Requirements
- R1: After reset, `pool_empty` is 0, `rd_valid` is 0 and `mw_req` is 0 while `in_valid` is 0.
- R2: Tokens are handed out in free-list order. The first 4096 events take tokens 0 to 4095 in ascending order. After that, returned tokens are reused in the order in which they came back. The token of an event is `mw_addr[26:15]`.
- R3: The byte address of word k of an event is token·32768 + 4·k, so `mw_addr[14:2]` = k and `mw_addr[1:0]` = 0.
- R4: A word that is not truncated is written unchanged. Bit 32 is 1 only on the final word of its event.
- R5: If an event reaches its 8192nd word and that word has bit 32 = 0, the word is written with bit 32 = 1 and bit 31 = 1 (the overflow flag). The event's further words, up to and including the one with bit 32 = 1, are accepted with `in_ready` = 1 and no memory request.
- R6: An event of exactly 8192 words whose last word has bit 32 = 1 is stored without the overflow flag, and its readout count is 8192.
- R7: Completed events appear on the readout side in completion order, with `rd_token` and `rd_words` (the number of stored words). The entry is held until `rd_take` is pulsed.
- R8: `pool_empty` is 1 exactly when no token is free. While it is 1, the first word of a new event sees `in_ready` = 0 and causes no request. An event that already holds a token continues to write normally.
- R9: A token returned through `ret_valid`/`ret_token` becomes available again, clears `pool_empty`, and is taken by a later event.
- R10: When a word is not being dropped, `in_ready` is 1 only while `mw_ack` is 1. A word transfers on the cycle in which `mw_req` and `mw_ack` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Event word present |
| in_ready | output | 1 | Event word accepted this cycle |
| in_data | input | 33 | Event word; bit 32 marks the last word |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | 27 | Memory byte address |
| mw_data | output | 33 | Word to store; bit 32 final, bit 31 carries overflow |
| mw_ack | input | 1 | Memory accepts the write |
| rd_valid | output | 1 | A completed event is queued for readout |
| rd_token | output | 12 | Token of the queued event |
| rd_words | output | 14 | Stored word count of the queued event |
| rd_take | input | 1 | Reader takes the queued entry |
| ret_valid | input | 1 | Reader hands a token back |
| ret_token | input | 12 | Token being handed back |
| pool_empty | output | 1 | No free token left |

## Verification
A wrong free-list pointer or a wrong fresh-token counter shows up at once: the upper address bits of the next event's first write name the wrong token. A fault in the word counter shows up in the low address bits within one transfer, and it moves the truncation point, which the overflow flag and the readout count then expose. A lost or duplicated token shows up only later, either as a wrong `pool_empty` edge after the pool has been drained or as a stale token being reused. For that reason the stimulus drains the whole pool and reuses tokens in a known order.

// File: rtl/event_buf_mgr.sv
module event_buf_mgr #(
  parameter int TOK_W    = 12,
  parameter int WORD_LG2 = 13,
  parameter int DW       = 33
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DW-1:0]                in_data,
  output logic                         mw_req,
  output logic [TOK_W+WORD_LG2+1:0]    mw_addr,
  output logic [DW-1:0]                mw_data,
  input  logic                         mw_ack,
  output logic                         rd_valid,
  output logic [TOK_W-1:0]             rd_token,
  output logic [WORD_LG2:0]            rd_words,
  input  logic                         rd_take,
  input  logic                         ret_valid,
  input  logic [TOK_W-1:0]             ret_token,
  output logic                         pool_empty
);
  localparam int NTOK = 1 << TOK_W;
  localparam int CW   = TOK_W + 1;
  localparam int LW   = WORD_LG2 + 1;

  logic [CW-1:0]    fresh;
  logic [TOK_W-1:0] fl_mem [NTOK];
  logic [TOK_W-1:0] fl_rd, fl_wr;
  logic [CW-1:0]    fl_cnt;

  logic [TOK_W+LW-1:0] dq_mem [NTOK];
  logic [TOK_W-1:0]    dq_rd, dq_wr;
  logic [CW-1:0]       dq_cnt;

  logic                active, dropping;
  logic [TOK_W-1:0]    cur_tok;
  logic [WORD_LG2-1:0] wcnt;

  wire fresh_left = !fresh[TOK_W];
  wire [TOK_W-1:0] head_tok = fresh_left ? fresh[TOK_W-1:0] : fl_mem[fl_rd];
  wire [TOK_W-1:0] tok_now  = active ? cur_tok : head_tok;
  wire is_last   = in_data[DW-1];
  wire at_limit  = &wcnt;
  wire trunc     = at_limit && !is_last;
  wire fin       = is_last || at_limit;
  wire can_write = active || !pool_empty;
  wire fire_w    = mw_req && mw_ack;
  wire alloc     = fire_w && !active;
  wire pop_fl    = alloc && !fresh_left;
  wire push_dq   = fire_w && fin;
  wire pop_dq    = rd_valid && rd_take;

  assign pool_empty = !fresh_left && (fl_cnt == '0);
  assign mw_req     = in_valid && !dropping && can_write;
  assign in_ready   = dropping || (can_write && mw_ack);
  assign mw_addr    = {tok_now, wcnt, 2'b00};
  assign mw_data    = {fin, in_data[DW-2] | trunc, in_data[DW-3:0]};
  assign rd_valid   = dq_cnt != '0;
  assign {rd_token, rd_words} = dq_mem[dq_rd];

  always_ff @(posedge clk) begin
    if (ret_valid) fl_mem[fl_wr] <= ret_token;
    if (push_dq)   dq_mem[dq_wr] <= {tok_now, LW'(wcnt) + LW'(1)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh    <= '0;
      fl_rd    <= '0;
      fl_wr    <= '0;
      fl_cnt   <= '0;
      dq_rd    <= '0;
      dq_wr    <= '0;
      dq_cnt   <= '0;
      active   <= 1'b0;
      dropping <= 1'b0;
      cur_tok  <= '0;
      wcnt     <= '0;
    end else begin
      if (alloc && fresh_left) fresh <= fresh + CW'(1);
      if (pop_fl)    fl_rd <= fl_rd + TOK_W'(1);
      if (ret_valid) fl_wr <= fl_wr + TOK_W'(1);
      fl_cnt <= fl_cnt + CW'(ret_valid) - CW'(pop_fl);

      if (push_dq) dq_wr <= dq_wr + TOK_W'(1);
      if (pop_dq)  dq_rd <= dq_rd + TOK_W'(1);
      dq_cnt <= dq_cnt + CW'(push_dq) - CW'(pop_dq);

      if (fire_w) begin
        if (fin) begin
          active   <= 1'b0;
          wcnt     <= '0;
          dropping <= trunc;
        end else begin
          active  <= 1'b1;
          cur_tok <= tok_now;
          wcnt    <= wcnt + WORD_LG2'(1);
        end
      end else if (dropping && in_valid && is_last) begin
        dropping <= 1'b0;
      end
    end
  end
endmodule

module event_buf_mgr_chk #(
  parameter int TOK_W    = 12,
  parameter int WORD_LG2 = 13,
  parameter int DW       = 33
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [DW-1:0]             in_data,
  input logic                      mw_req,
  input logic [TOK_W+WORD_LG2+1:0] mw_addr,
  input logic [DW-1:0]             mw_data,
  input logic                      mw_ack,
  input logic                      rd_valid,
  input logic [TOK_W-1:0]          rd_token,
  input logic [WORD_LG2:0]         rd_words,
  input logic                      rd_take,
  input logic                      pool_empty,
  input logic                      active,
  input logic                      dropping
);
  localparam int AW   = TOK_W + WORD_LG2 + 2;
  localparam int MAXW = 1 << WORD_LG2;

  a_r8_no_alloc_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req && !active) |-> !pool_empty);

  a_r8_stall_new_event: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_empty && !active && !dropping && in_valid) |-> !in_ready);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mw_req && mw_ack && !mw_data[DW-1]) && mw_req) |-> (mw_addr == $past(mw_addr) + AW'(4)));

  a_r5_ovf_only_final: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req && mw_data[DW-2] && !in_data[DW-2]) |-> mw_data[DW-1]);

  a_r7_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_take) |=> (rd_valid && $stable(rd_token) && $stable(rd_words)));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_words != '0 && 32'(rd_words) <= MAXW));

  a_r10_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !dropping) |-> mw_ack);
endmodule

bind event_buf_mgr event_buf_mgr_chk #(.TOK_W(TOK_W), .WORD_LG2(WORD_LG2), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
  .rd_valid(rd_valid), .rd_token(rd_token), .rd_words(rd_words), .rd_take(rd_take),
  .pool_empty(pool_empty), .active(active), .dropping(dropping)
);

// File: tb/event_buf_mgr_test.sv
`timescale 1ns/1ps
module event_buf_mgr_test;
  localparam int MAXW = 8192;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, mw_req, mw_ack = 0, rd_valid, rd_take = 0, ret_valid = 0, pool_empty;
  logic [32:0] in_data = '0, mw_data;
  logic [26:0] mw_addr;
  logic [11:0] rd_token, ret_token = '0;
  logic [13:0] rd_words;

  int checks = 0, fails = 0;
  int free_q[$], done_tok[$], done_len[$], held[$];

  always #2.5 clk = ~clk;

  event_buf_mgr uut (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_event(input int n, input bit ends);
    int tok = 0, w = 0;
    bit drop = 0, started = 0;
    for (int i = 0; i < n; i++) begin
      logic [32:0] d;
      bit lst;
      lst = ends && (i == n - 1);
      d = {lst, 1'b0, 31'($urandom)};
      @(negedge clk); in_valid = 1; in_data = d;
      mw_ack = ($urandom % 4) != 0; #1;
      if (!drop && !mw_ack) chk(!in_ready, "R10", "ready without ack", in_ready, 0);
      while (!in_ready) begin
        @(negedge clk); mw_ack = ($urandom % 4) != 0; #1;
      end
      if (drop) begin
        chk(!mw_req, "R5", "dropped word requested", mw_req, 0);
        if (lst) drop = 0;
      end else begin
        bit fin, tr;
        logic [26:0] ea;
        logic [32:0] ed;
        if (!started) begin tok = free_q.pop_front(); started = 1; end
        ea = {tok[11:0], w[12:0], 2'b00};
        fin = lst || (w == MAXW - 1);
        tr = (w == MAXW - 1) && !lst;
        ed = {fin, d[31] | tr, d[30:0]};
        chk(mw_req && mw_addr[26:15] == ea[26:15], "R2", "token in address", mw_addr[26:15], ea[26:15]);
        chk(mw_addr[14:0] == ea[14:0], "R3", "word offset", mw_addr[14:0], ea[14:0]);
        if (tr) chk(mw_data == ed, "R5", "truncated final word", mw_data, ed);
        else if (w == MAXW - 1) chk(mw_data == ed, "R6", "full-size final word", mw_data, ed);
        else chk(mw_data == ed, "R4", "stored word", mw_data, ed);
        w++;
        if (fin) begin
          done_tok.push_back(tok); done_len.push_back(w);
          started = 0; w = 0; drop = tr;
        end
      end
    end
    @(negedge clk); in_valid = 0; mw_ack = 0;
  endtask

  task automatic drain(input bit give);
    int t, l;
    t = done_tok.pop_front(); l = done_len.pop_front();
    @(negedge clk); #1;
    chk(rd_valid && rd_token == t[11:0], "R7", "readout token", rd_token, t);
    chk(rd_words == l[13:0], l == MAXW ? "R6" : "R7", "readout count", rd_words, l);
    rd_take = 1;
    if (give) begin ret_valid = 1; ret_token = t[11:0]; end
    @(negedge clk); rd_take = 0; ret_valid = 0;
    if (give) free_q.push_back(t); else held.push_back(t);
  endtask

  task automatic give_back(input int t);
    @(negedge clk); ret_valid = 1; ret_token = t[11:0];
    @(negedge clk); ret_valid = 0;
    free_q.push_back(t);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) free_q.push_back(i);
    repeat (4) @(negedge clk);
    #1;
    chk(!pool_empty, "R1", "pool_empty after reset", pool_empty, 0);
    chk(!rd_valid, "R1", "rd_valid after reset", rd_valid, 0);
    chk(!mw_req, "R1", "mw_req after reset", mw_req, 0);
    @(negedge clk); rst_n = 1;

    for (int e = 0; e < 8; e++) send_event(1 + int'($urandom % 40), 1);
    repeat (3) @(negedge clk);
    #1 chk(rd_valid, "R7", "held entry still valid", rd_valid, 1);
    for (int e = 0; e < 8; e++) drain(1);

    send_event(MAXW + 8, 1);
    drain(1);
    send_event(MAXW, 1);
    drain(1);

    for (int e = 0; e < 3; e++) send_event(2 + e, 1);
    for (int e = 0; e < 3; e++) drain(0);
    for (int e = 2; e >= 0; e--) give_back(held[e]);
    held.delete();

    while (free_q.size() > 1) begin
      send_event(1, 1);
      drain(0);
    end
    send_event(5, 1);
    #1 chk(pool_empty, "R8", "pool empty after last token", pool_empty, 1);
    drain(0);

    @(negedge clk); in_valid = 1; in_data = {1'b1, 32'h5};
    for (int c = 0; c < 3; c++) begin
      mw_ack = 1; #1;
      chk(!in_ready && !mw_req, "R8", "new event stalls when empty", {in_ready, mw_req}, 0);
      @(negedge clk);
    end
    in_valid = 0; mw_ack = 0;

    give_back(held[3]);
    #1 chk(!pool_empty, "R9", "pool refilled by return", pool_empty, 0);
    chk(free_q[0] == held[3], "R9", "returned token queued", free_q[0], held[3]);
    send_event(2, 1);
    drain(1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule